// File: doc/BRIEF.md
# Address-Matching Synapse Row

This block models one row of synapses that listens to a shared, time-multiplexed event bus. Each bus event carries a 6-bit source address and a valid strobe, so up to 64 presynaptic sources can share the row. Every column holds its own source address and weight. Each column checks the bus address against its stored address. On a hit it launches a drive pulse of fixed length, measured in clock cycles. While the pulse runs, the pulse carries the stored weight as its amplitude tag.

A single row-wide select chooses which of two dendritic inputs the pulses drive. The select is latched when a pulse starts, so changing it later does not split a running pulse across the two inputs. Every hit also raises a one-cycle presynaptic flag for the correlation logic, including hits on a column whose weight is zero. A zero weight gives no drive pulse.

A column-addressed write port loads a column's address and weight. The pulse latches its weight at launch, so a write never alters a pulse already in flight.

Top module: `syn_row`

## Requirements
- R1: After reset all outputs are low and every column holds address 0 and weight 0. An event on address 0 therefore flags every column and drives none.
- R2: A column responds only to a bus cycle with `ev_valid` high whose `ev_addr` equals its stored address. Several columns holding the same address all respond to one event.
- R3: A hit on a column with non-zero weight raises `pulse_en[c]` from the cycle after the event for exactly PULSE_CYC cycles. During those cycles `pulse_wt[c*6 +: 6]` shows the weight stored at the event. At all other times it reads 0.
- R4: A new launching hit on a column whose pulse is running restarts that pulse at full length, with the weight current at the new event.
- R5: Every hit raises `pre_evt[c]` for one cycle, one cycle after the event. A hit on a zero-weight column starts no pulse and leaves a running pulse of that column unchanged.
- R6: `line_sel` is sampled when a pulse launches: 0 sends the pulse on `dend_a[c]`, 1 on `dend_b[c]`. The choice holds for the whole pulse, and at most one of the two is high.
- R7: When `cfg_we` is high, the column given by `cfg_col` takes `cfg_addr` and `cfg_weight`. The new values take effect for events from the following cycle. An event in the same cycle as the write is compared with the old address.
- R8: A write to a column whose pulse is running changes neither the pulse length, nor its weight tag, nor its line.
- R9: Events are accepted on every clock cycle with no gaps, each one judged on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Bus event strobe |
| ev_addr | input | AW (6) | Source address on the bus |
| line_sel | input | 1 | Row-wide target line: 0 = input A, 1 = input B |
| cfg_we | input | 1 | Configuration write enable |
| cfg_col | input | clog2(NCOL) | Column to write |
| cfg_addr | input | AW (6) | Source address to store |
| cfg_weight | input | WW (6) | Weight to store |
| pulse_en | output | NCOL | Per-column pulse active |
| pulse_wt | output | NCOL*WW | Per-column weight tag, column c at bits c*WW +: WW |
| dend_a | output | NCOL | Pulse routed to dendritic input A |
| dend_b | output | NCOL | Pulse routed to dendritic input B |
| pre_evt | output | NCOL | One-cycle presynaptic event flag |

## Verification
A configuration write and an event match can hit the same column in the same cycle. The same holds for a write and the decrement of a running pulse. The bench provokes the first by writing a new address to a column while the bus carries that column's old address, and it expects the old address to match. It then sends the old address again one cycle later and expects no response. It provokes the second by writing a new weight while a pulse runs, and it expects the length and tag of the running pulse to be unchanged. A scoreboard built from the requirements predicts every output on every cycle.

// File: rtl/syn_row.sv
module syn_row #(
  parameter int NCOL      = 8,
  parameter int AW        = 6,
  parameter int WW        = 6,
  parameter int PULSE_CYC = 4,
  localparam int CIW = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int CW  = $clog2(PULSE_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [AW-1:0]      ev_addr,
  input  logic               line_sel,
  input  logic               cfg_we,
  input  logic [CIW-1:0]     cfg_col,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [WW-1:0]      cfg_weight,
  output logic [NCOL-1:0]    pulse_en,
  output logic [NCOL*WW-1:0] pulse_wt,
  output logic [NCOL-1:0]    dend_a,
  output logic [NCOL-1:0]    dend_b,
  output logic [NCOL-1:0]    pre_evt
);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [AW-1:0] adr_q;
    logic [WW-1:0] wt_q, hold_wt;
    logic [CW-1:0] cnt;
    logic          hold_sel, pre_q;
    logic          hit, fire, wr;

    assign hit  = ev_valid && (adr_q == ev_addr);
    assign fire = hit && (wt_q != '0);
    assign wr   = cfg_we && (cfg_col == CIW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        adr_q    <= '0;
        wt_q     <= '0;
        hold_wt  <= '0;
        hold_sel <= 1'b0;
        cnt      <= '0;
        pre_q    <= 1'b0;
      end else begin
        pre_q <= hit;
        if (fire) begin
          cnt      <= CW'(PULSE_CYC);
          hold_wt  <= wt_q;
          hold_sel <= line_sel;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
        if (wr) begin
          adr_q <= cfg_addr;
          wt_q  <= cfg_weight;
        end
      end
    end

    assign pulse_en[c]          = (cnt != '0);
    assign pulse_wt[c*WW +: WW] = pulse_en[c] ? hold_wt : '0;
    assign dend_a[c]            = pulse_en[c] & ~hold_sel;
    assign dend_b[c]            = pulse_en[c] &  hold_sel;
    assign pre_evt[c]           = pre_q;
  end

endmodule

// File: rtl/syn_row_chk.sv
module syn_row_chk #(
  parameter int NCOL = 8,
  parameter int WW   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_valid,
  input logic [NCOL-1:0]    pulse_en,
  input logic [NCOL*WW-1:0] pulse_wt,
  input logic [NCOL-1:0]    dend_a,
  input logic [NCOL-1:0]    dend_b,
  input logic [NCOL-1:0]    pre_evt
);

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (|pre_evt) |-> $past(ev_valid)); // R2

  for (genvar c = 0; c < NCOL; c++) begin : g_chk
    AST_LAUNCH_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_en[c]) |-> pre_evt[c]); // R3

    AST_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_en[c] |-> (pulse_wt[c*WW +: WW] != '0)); // R5

    AST_TAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_en[c] && $past(pulse_en[c]) && !pre_evt[c]) |-> $stable(pulse_wt[c*WW +: WW])); // R8

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dend_a[c], dend_b[c]})); // R6

    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_en[c] && $past(pulse_en[c]) && !pre_evt[c]) |-> $stable(dend_b[c])); // R6
  end

endmodule

bind syn_row syn_row_chk #(.NCOL(NCOL), .WW(WW)) u_chk (.*);

// File: tb/test_syn_row.sv
module test_syn_row;
  localparam int NCOL = 8;
  localparam int AW   = 6;
  localparam int WW   = 6;
  localparam int P    = 4;
  localparam int CIW  = $clog2(NCOL);

  typedef struct {
    logic [NCOL-1:0]    pre;
    logic [NCOL-1:0]    en;
    logic [NCOL*WW-1:0] wt;
    logic [NCOL-1:0]    a;
    logic [NCOL-1:0]    b;
    string              tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, line_sel = 0, cfg_we = 0;
  logic [AW-1:0] ev_addr = '0, cfg_addr = '0;
  logic [CIW-1:0] cfg_col = '0;
  logic [WW-1:0] cfg_weight = '0;
  logic [NCOL-1:0] pulse_en, dend_a, dend_b, pre_evt;
  logic [NCOL*WW-1:0] pulse_wt;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  logic [AW-1:0] m_addr [NCOL];
  logic [WW-1:0] m_wt [NCOL], m_hw [NCOL];
  int            m_cnt [NCOL];
  logic          m_hs [NCOL];

  always #4 clk = ~clk;

  syn_row #(.NCOL(NCOL), .AW(AW), .WW(WW), .PULSE_CYC(P)) i_syn_row (.*);

  task automatic step(input logic v, input logic [AW-1:0] a, input logic sel,
                      input logic we, input int col, input logic [AW-1:0] ca,
                      input logic [WW-1:0] cw, input string tag);
    exp_t e;
    @(negedge clk);
    ev_valid = v; ev_addr = a; line_sel = sel;
    cfg_we = we; cfg_col = CIW'(col); cfg_addr = ca; cfg_weight = cw;
    e.tag = tag;
    for (int c = 0; c < NCOL; c++) begin
      logic hit;
      hit = v && (m_addr[c] == a);
      e.pre[c] = hit;
      if (hit && m_wt[c] != 0) begin
        m_cnt[c] = P; m_hw[c] = m_wt[c]; m_hs[c] = sel;
      end else if (m_cnt[c] != 0) m_cnt[c]--;
      if (we && col == c) begin m_addr[c] = ca; m_wt[c] = cw; end
      e.en[c] = (m_cnt[c] != 0);
      e.wt[c*WW +: WW] = e.en[c] ? m_hw[c] : '0;
      e.a[c] = e.en[c] & ~m_hs[c];
      e.b[c] = e.en[c] &  m_hs[c];
    end
    q.push_back(e);
  endtask

  task automatic ev(input logic [AW-1:0] a, input logic sel, input string tag);
    step(1, a, sel, 0, 0, '0, '0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, '0, '0, tag);
  endtask

  task automatic wr(input int col, input logic [AW-1:0] ca, input logic [WW-1:0] cw, input string tag);
    step(0, '0, 0, 1, col, ca, cw, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pre_evt !== e.pre || pulse_en !== e.en || pulse_wt !== e.wt ||
          dend_a !== e.a || dend_b !== e.b) begin
        errors++;
        $display("FAIL %s: pre=%h en=%h wt=%h a=%h b=%h expected pre=%h en=%h wt=%h a=%h b=%h",
                 e.tag, pre_evt, pulse_en, pulse_wt, dend_a, dend_b,
                 e.pre, e.en, e.wt, e.a, e.b);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_up();
  end

  initial begin
    for (int c = 0; c < NCOL; c++) begin
      m_addr[c] = '0; m_wt[c] = '0; m_hw[c] = '0; m_cnt[c] = 0; m_hs[c] = 0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (pulse_en !== '0 || pulse_wt !== '0 || dend_a !== '0 || dend_b !== '0 || pre_evt !== '0) begin
      errors++;
      $display("FAIL R1: outputs %h %h %h %h %h expected all zero",
               pulse_en, pulse_wt, dend_a, dend_b, pre_evt);
    end
    rst_n = 1;
    // R1: address 0 flags all columns, weight 0 drives none
    ev(6'd0, 0, "R1");
    idle(2, "R1");
    // R7: load columns
    for (int c = 0; c < NCOL; c++)
      wr(c, AW'(c + 10), (c == 3) ? WW'(0) : WW'(c + 1), "R7");
    wr(5, 6'd12, 6'd33, "R7");
    // R2 R3: columns 2 and 5 share address 12
    ev(6'd12, 0, "R2");
    idle(6, "R3");
    // R2: valid low ignored
    step(0, 6'd12, 0, 0, 0, '0, '0, "R2");
    idle(2, "R2");
    // R5: zero-weight column flags only
    ev(6'd13, 0, "R5");
    idle(2, "R5");
    // R4: retrigger restarts
    ev(6'd10, 0, "R4");
    idle(2, "R4");
    ev(6'd10, 0, "R4");
    idle(6, "R4");
    // R6: line B, select changed mid-pulse
    ev(6'd11, 1, "R6");
    step(0, '0, 0, 0, 0, '0, '0, "R6");
    ev(6'd14, 0, "R6");
    idle(6, "R6");
    // R8: write weight during pulse
    ev(6'd14, 1, "R8");
    wr(4, 6'd14, 6'd50, "R8");
    idle(5, "R8");
    ev(6'd14, 0, "R8");
    idle(5, "R8");
    // R7: write and event same cycle compare old address
    step(1, 6'd12, 0, 1, 5, 6'd40, 6'd7, "R7");
    ev(6'd12, 0, "R7");
    ev(6'd40, 1, "R7");
    idle(6, "R7");
    // R5: zero-weight hit during running pulse
    ev(6'd11, 0, "R5");
    wr(1, 6'd11, 6'd0, "R5");
    ev(6'd11, 1, "R5");
    idle(5, "R5");
    // R9: back-to-back events
    for (int i = 0; i < 12; i++) ev(AW'(10 + (i % 8)), i[0], "R9");
    ev(6'd40, 0, "R9");
    idle(8, "R9");
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule